// File: doc/BRIEF.md
# Oversampled Serial Receive Engine

This block recovers characters from an asynchronous serial line. A clock enable, supplied from outside, pulses sixteen times per bit period, and every decision the receiver makes happens on one of those pulses. The line first passes through a two-stage synchronizer. A falling level is treated as a start bit only once it has held low long enough. Short low pulses are rejected as noise.

Once a start bit is accepted, the engine samples each following bit at its centre. It gathers eight data bits, least significant first, then an optional parity bit and one stop bit. The result goes into a holding register with a ready flag and error flags. A read strobe takes the character. A one-cycle receiver-reset strobe drops any frame in progress and leaves the engine switched off until an enable strobe turns it back on.

Top module: `serial_rx_core`

## Requirements
- R1: While `rst_n` is low and on the cycle after it, `rx_ready`, `parity_err`, `frame_err`, `overrun`, `rx_enabled` and `rx_data` are all 0. A one-cycle pulse on `rx_enable` sets `rx_enabled` on the next clock edge.
- R2: The line idles high. A start bit is accepted only if the synchronized line is low on more than 7 consecutive `tick` cycles (8 or more). A low lasting 7 ticks or fewer is discarded and the engine waits for a new falling level.
- R3: Counting the first tick that sees the line low as tick 0, D0 is sampled on tick 24. Each later bit is sampled 16 ticks after the one before it. Data arrives least significant bit first.
- R4: `par_mode` selects the parity bit that follows D7: 0 none, 1 even (the data and parity together hold an even number of ones), 2 odd, 3 mark (always 1), 4 space (always 0). Codes 5 to 7 act as none. A mismatch sets `parity_err` together with `rx_ready`. With no parity, `parity_err` is 0.
- R5: A low stop-bit sample sets `frame_err` for that character. The character is still delivered.
- R6: On the clock edge of the tick that samples the stop bit, the character is loaded into `rx_data` and `rx_ready` goes to 1. `rx_data` changes at no other time.
- R7: A one-cycle `rd_strobe` clears `rx_ready` and `overrun` on the next edge, unless a character completes on that same cycle.
- R8: A `rx_reset` pulse returns the engine to waiting for a start bit and clears `rx_enabled` on the next edge. A partly received character is dropped, and `rx_data` and `rx_ready` keep their values.
- R9: While `rx_enabled` is 0, activity on the line starts no frame and produces no character.
- R10: If a character completes while `rx_ready` is 1 and no read happens on that cycle, `rx_data` is overwritten and `overrun` is set.
- R11: State advances only on cycles where `tick` is 1. A character completes only on such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample enable, sixteen pulses per bit |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rx_enable | input | 1 | One-cycle strobe that switches the receiver on |
| rx_reset | input | 1 | One-cycle strobe that aborts and switches the receiver off |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| par_mode | input | 3 | Parity selection code |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | A character is waiting |
| parity_err | output | 1 | Parity mismatch on the latest character |
| frame_err | output | 1 | Stop bit was low on the latest character |
| overrun | output | 1 | An unread character was overwritten |
| rx_enabled | output | 1 | Receiver is switched on |

## Verification
The properties assume that `rd_strobe`, `rx_reset` and `rx_enable` are single-cycle pulses. They also assume `par_mode` stays fixed for the length of a frame, and that `tick` is never high on two cycles in a row. The bench produces `tick` on every fourth clock from a divider of its own. It changes the line only on the falling clock edge right after a tick, so every bit is exactly sixteen ticks long. It holds the parity code between frames, and it drives each strobe high for exactly one clock.

// File: rtl/serial_rx_pkg.sv
// Package: encodings shared by the serial receive engine.
// Assumes: parity codes match the requirement table of the brief.
package serial_rx_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/rx_sync_chain.sv
// Module: rx_sync_chain
// Does: brings an asynchronous level into the clock domain through a
//       chain of flops.
// Assumes: the input idles high, so the chain resets to 1.
module rx_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the chain; reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
// Module: rx_frame_fsm
// Does: qualifies the start bit, then samples data, parity and stop at
//       the centre of each bit. Counts ticks with one wrapping counter.
// Assumes: tick is a one-cycle enable at OSR times the baud rate;
//          START_LOW_MIN <= OSR/2; par_mode is held through a frame.
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS     = 8,
    parameter int OSR           = 16,
    parameter int START_LOW_MIN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 enabled,
    input  logic                 abort,
    input  logic [2:0]           par_mode,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr,
    output logic                 ferr,
    output logic                 busy
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] MID_C        = CW'(OSR / 2);
    localparam logic [CW-1:0] START_LAST_C = CW'(START_LOW_MIN - 1);
    localparam logic [BW-1:0] LAST_BIT_C   = BW'(DATA_BITS - 1);

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [CW-1:0]        nxt;
    logic [BW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 perr_q;
    logic                 par_on;
    logic                 exp_par;

    // Next tick count and the parity bit the current data calls for.
    always_comb begin
        nxt     = cnt + 1'b1;
        par_on  = 1'b1;
        exp_par = 1'b0;
        case (par_mode)
            PAR_EVEN:  exp_par = ^shreg;
            PAR_ODD:   exp_par = ~^shreg;
            PAR_MARK:  exp_par = 1'b1;
            PAR_SPACE: exp_par = 1'b0;
            default:   par_on  = 1'b0;
        endcase
    end

    // Frame sequencer: an abort or a disabled receiver forces idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            perr_q  <= 1'b0;
        end else if (abort || !enabled) begin
            state <= ST_IDLE;
        end else if (tick) begin
            cnt <= nxt;
            case (state)
                ST_IDLE: begin
                    if (!line) begin
                        state  <= ST_START;
                        cnt    <= '0;
                        perr_q <= 1'b0;
                    end
                end
                ST_START: begin
                    if (line && nxt <= START_LAST_C) begin
                        state <= ST_IDLE;
                    end else if (nxt == MID_C) begin
                        state   <= ST_DATA;
                        bit_idx <= '0;
                    end
                end
                ST_DATA: begin
                    if (nxt == MID_C) begin
                        shreg   <= {line, shreg[DATA_BITS-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == LAST_BIT_C)
                            state <= par_on ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (nxt == MID_C) begin
                        perr_q <= (line != exp_par);
                        state  <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (nxt == MID_C) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Completion on the stop-bit centre tick, unless aborted that cycle.
    assign done = tick && enabled && !abort && (state == ST_STOP) && (nxt == MID_C);
    assign data = shreg;
    assign perr = perr_q;
    assign ferr = !line;
    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/rx_hold_reg.sv
// Module: rx_hold_reg
// Does: holds the last character, its error flags, the ready flag and
//       the overrun flag.
// Assumes: done and rd are one-cycle pulses; a completion on the same
//          cycle as a read wins over the read.
module rx_hold_reg #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 perr_in,
    input  logic                 ferr_in,
    input  logic                 rd,
    output logic [DATA_BITS-1:0] dout,
    output logic                 ready,
    output logic                 perr,
    output logic                 ferr,
    output logic                 ovr
);
    // Load on completion, otherwise release on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end else if (done) begin
            dout  <= din;
            ready <= 1'b1;
            perr  <= perr_in;
            ferr  <= ferr_in;
            ovr   <= !rd && (ready || ovr);
        end else if (rd) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
// Module: serial_rx_core (top)
// Does: ties together the synchronizer, the frame sequencer, the
//       holding register and the on/off control.
// Assumes: tick comes from an external baud divider at sixteen times
//          the bit rate; strobes last one cycle.
module serial_rx_core #(
    parameter int DATA_BITS     = 8,
    parameter int OSR           = 16,
    parameter int START_LOW_MIN = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_line,
    input  logic                 rx_enable,
    input  logic                 rx_reset,
    input  logic                 rd_strobe,
    input  logic [2:0]           par_mode,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 overrun,
    output logic                 rx_enabled
);
    logic                 line_s;
    logic                 frame_done;
    logic                 fsm_busy;
    logic [DATA_BITS-1:0] fsm_data;
    logic                 fsm_perr;
    logic                 fsm_ferr;

    // On/off control: a reset strobe outranks an enable strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_enabled <= 1'b0;
        else if (rx_reset)  rx_enabled <= 1'b0;
        else if (rx_enable) rx_enabled <= 1'b1;
    end

    rx_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_line),
        .sync_out (line_s)
    );

    rx_frame_fsm #(
        .DATA_BITS     (DATA_BITS),
        .OSR           (OSR),
        .START_LOW_MIN (START_LOW_MIN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .line     (line_s),
        .enabled  (rx_enabled),
        .abort    (rx_reset),
        .par_mode (par_mode),
        .done     (frame_done),
        .data     (fsm_data),
        .perr     (fsm_perr),
        .ferr     (fsm_ferr),
        .busy     (fsm_busy)
    );

    rx_hold_reg #(.DATA_BITS(DATA_BITS)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (frame_done),
        .din     (fsm_data),
        .perr_in (fsm_perr),
        .ferr_in (fsm_ferr),
        .rd      (rd_strobe),
        .dout    (rx_data),
        .ready   (rx_ready),
        .perr    (parity_err),
        .ferr    (frame_err),
        .ovr     (overrun)
    );
endmodule

// File: rtl/serial_rx_checker.sv
// Module: serial_rx_checker
// Does: temporal properties of the receive engine, bound to the top.
// Assumes: strobes are single-cycle and tick is never high twice in a row.
module serial_rx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 rx_reset,
    input logic                 rd_strobe,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_ready,
    input logic                 overrun,
    input logic                 rx_enabled,
    input logic                 frame_done,
    input logic                 fsm_busy
);
    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> tick); // R11
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> rx_ready); // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) !frame_done |=> $stable(rx_data)); // R6
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (rd_strobe && !frame_done) |=> (!rx_ready && !overrun)); // R7
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n) rx_reset |=> (!fsm_busy && !rx_enabled)); // R8
    AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rx_enabled |-> !fsm_busy); // R9
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(overrun) |-> $past(rx_ready)); // R10
endmodule

bind serial_rx_core serial_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rx_reset   (rx_reset),
    .rd_strobe  (rd_strobe),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .overrun    (overrun),
    .rx_enabled (rx_enabled),
    .frame_done (frame_done),
    .fsm_busy   (fsm_busy)
);

// File: tb/sim_serial_rx_core.sv
// Bench: scoreboard for serial_rx_core. The driver pushes expected
// characters; a monitor pops and compares them when rx_ready rises.
module sim_serial_rx_core;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_enable = 1'b0;
    logic       rx_reset = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic [7:0] rx_data;
    logic       rx_ready, parity_err, frame_err, overrun, rx_enabled;

    int n_cmp = 0;
    int n_bad = 0;
    bit auto_rd = 1'b1;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
    } exp_t;
    exp_t exp_q[$];

    serial_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
        .rx_enable(rx_enable), .rx_reset(rx_reset), .rd_strobe(rd_strobe),
        .par_mode(par_mode), .rx_data(rx_data), .rx_ready(rx_ready),
        .parity_err(parity_err), .frame_err(frame_err), .overrun(overrun),
        .rx_enabled(rx_enabled)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick divider, updated on the falling edge so it is stable at posedge.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TICK_DIV;
        tick = (tdiv == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Wait n ticks; return on the falling edge after the last tick.
    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic hold_line(input logic lvl, input int n);
        rx_line = lvl;
        wait_ticks(n);
    endtask

    function automatic logic par_bit(input logic [7:0] d, input logic [2:0] m);
        case (m)
            3'd1:    return ^d;
            3'd2:    return ~^d;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Driver: one whole frame, LSB first; optionally queue the expectation.
    task automatic send_frame(input logic [7:0] d, input logic [2:0] m,
                              input bit bad_par, input logic stop, input bit expect_it);
        bit has_par;
        exp_t e;
        has_par = (m >= 3'd1 && m <= 3'd4);
        par_mode = m;
        wait_ticks(1);
        if (expect_it) begin
            e.d = d; e.pe = has_par && bad_par; e.fe = !stop;
            exp_q.push_back(e);
        end
        hold_line(1'b0, 16);
        for (int b = 0; b < 8; b++) hold_line(d[b], 16);
        if (has_par) hold_line(par_bit(d, m) ^ bad_par, 16);
        hold_line(stop, 16);
        hold_line(1'b1, 6);
    endtask

    // Monitor: compare each new character, then read it out.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && rx_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R9 unexpected character", int'(rx_data), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rx_data == e.d, "R3 data", int'(rx_data), int'(e.d));
                    check(parity_err == e.pe, "R4 parity_err", int'(parity_err), int'(e.pe));
                    check(frame_err == e.fe, "R5 frame_err", int'(frame_err), int'(e.fe));
                end
                rd_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
                check(!rx_ready, "R7 ready after read", int'(rx_ready), 0);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!rx_ready && !parity_err && !frame_err && !overrun, "R1 flags in reset",
              int'({rx_ready, parity_err, frame_err, overrun}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_data == 8'h00, "R1 data after reset", int'(rx_data), 0);
        check(!rx_enabled, "R1 disabled after reset", int'(rx_enabled), 0);
        rx_enable = 1'b1;
        @(negedge clk);
        rx_enable = 1'b0;
        check(rx_enabled, "R1 enable strobe", int'(rx_enabled), 1);

        // R3 R4 R5 R6: patterns and every parity mode
        send_frame(8'hA5, 3'd0, 1'b0, 1'b1, 1'b1);
        send_frame(8'h3C, 3'd1, 1'b0, 1'b1, 1'b1);
        send_frame(8'h81, 3'd2, 1'b0, 1'b1, 1'b1);
        send_frame(8'h7E, 3'd1, 1'b1, 1'b1, 1'b1);
        send_frame(8'h00, 3'd3, 1'b0, 1'b1, 1'b1);
        send_frame(8'hFF, 3'd4, 1'b1, 1'b1, 1'b1);
        send_frame(8'h6B, 3'd2, 1'b1, 1'b1, 1'b1);
        send_frame(8'h55, 3'd0, 1'b0, 1'b0, 1'b1);
        send_frame(8'hC3, 3'd0, 1'b0, 1'b1, 1'b1);

        // R2: a 7-tick low is dropped
        par_mode = 3'd0;
        wait_ticks(2);
        hold_line(1'b0, 7);
        hold_line(1'b1, 200);
        check(!rx_ready && exp_q.size() == 0, "R2 short low rejected", int'(rx_ready), 0);
        send_frame(8'h12, 3'd0, 1'b0, 1'b1, 1'b1);

        // R2: exactly 8 low ticks is a start bit; rest high gives 0xFF
        wait_ticks(2);
        begin
            exp_t e;
            e.d = 8'hFF; e.pe = 1'b0; e.fe = 1'b0;
            exp_q.push_back(e);
        end
        hold_line(1'b0, 8);
        hold_line(1'b1, 200);
        check(exp_q.size() == 0, "R2 eight-tick start accepted", exp_q.size(), 0);

        // R10: overrun when the first character is left unread
        auto_rd = 1'b0;
        send_frame(8'h11, 3'd0, 1'b0, 1'b1, 1'b0);
        check(rx_ready && !overrun, "R10 first unread", int'({rx_ready, overrun}), 2);
        send_frame(8'h22, 3'd0, 1'b0, 1'b1, 1'b0);
        check(overrun, "R10 overrun set", int'(overrun), 1);
        check(rx_data == 8'h22, "R10 data overwritten", int'(rx_data), 8'h22);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check(!rx_ready && !overrun, "R7 read clears ready and overrun",
              int'({rx_ready, overrun}), 0);
        auto_rd = 1'b1;

        // R8: abort mid-frame; R11 ticks alone advance the engine
        fork
            send_frame(8'h3C, 3'd0, 1'b0, 1'b1, 1'b0);
            begin
                wait_ticks(70);
                rx_reset = 1'b1;
                @(negedge clk);
                rx_reset = 1'b0;
            end
        join
        check(!rx_enabled, "R8 disabled after reset strobe", int'(rx_enabled), 0);
        check(!rx_ready, "R8 partial frame dropped", int'(rx_ready), 0);
        check(rx_data == 8'h22, "R8 holding register kept", int'(rx_data), 8'h22);

        // R9: frames while off are ignored
        send_frame(8'h99, 3'd0, 1'b0, 1'b1, 1'b0);
        check(!rx_ready && rx_data == 8'h22, "R9 ignored while disabled", int'(rx_data), 8'h22);

        rx_enable = 1'b1;
        @(negedge clk);
        rx_enable = 1'b0;
        check(rx_enabled, "R1 re-enable", int'(rx_enabled), 1);
        send_frame(8'h5A, 3'd1, 1'b0, 1'b1, 1'b1);

        wait_ticks(20);
        check(exp_q.size() == 0, "R6 all characters delivered", exp_q.size(), 0);
        finish_run();
    end
endmodule